// File: doc/BRIEF.md
# Motor Drive Protection Supervisor

This block decides, cycle by cycle, whether a three-phase motor output stage may be energised. All of its protection timing is counted in pulses of a slow timebase tick, nominally about 5 Hz. It watches five inputs: a start/stop level, a tachometer level taken from one rotor position sensor, a reference clock level, and undervoltage and over-temperature flags. From these it produces a drive enable and three status flags.

After power-up the block holds the drive off for a fixed number of ticks. It then follows the start/stop level. While the motor runs, two tick counters are active. One is cleared by rising tachometer edges and shuts the drive down into a latched state if the rotor stops turning. The other is cleared by falling reference clock edges. When it expires, the drive is pulsed on and off with a fixed tick ratio until the clock comes back. A returning clock restores normal drive only while the stall latch is still clear. A stop request or a reset is the only way out of the latched state.

All asynchronous levels pass through synchroniser flops before use. The tick input is a one-cycle pulse that is synchronous to the system clock.

Top module: `motor_prot_sup`

## Requirements
- R1: While reset is asserted, and for the first INIT_TICKS (default 2) ticks after it, all four outputs are low.
- R2: With the start/stop input high (stop), drive_en_o is low and pwr_save_o is high. An undriven pin is expected to be pulled high.
- R3: When the start/stop input goes low from stop, the block enters run. drive_en_o goes high while the reference clock and tachometer are active and no fault is present.
- R4: In run, if STALL_TICKS (default 31) consecutive ticks pass with no valid tachometer edge, drive_en_o goes low and stall_latched_o goes high.
- R5: Only a rising tachometer edge (0 to 1) is a valid edge and clears the stall count. A falling edge does not clear it.
- R6: In run, if CLK_LOSS_TICKS (default 2) consecutive ticks pass with no falling reference clock edge (1 to 0), intermit_o goes high.
- R7: While intermit_o is high, drive_en_o repeats a pattern of INT_ON_TICKS ticks on followed by INT_OFF_TICKS ticks off (defaults 1 and 3). The pattern starts with the on phase.
- R8: A falling reference clock edge in run clears the clock-loss count. intermit_o drops and normal drive resumes.
- R9: Once latched, reference clock edges do not restore drive. Only a stop request (or reset) clears stall_latched_o, and the block then enters stop.
- R10: While undervoltage or over-temperature is high, drive_en_o is low and the stall count is held at zero. Drive returns when both flags clear.
- R11: At most one of pwr_save_o, stall_latched_o and intermit_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| run_n_i | input | 1 | Start/stop level, low = start |
| tach_i | input | 1 | Tachometer level |
| ref_i | input | 1 | Reference clock level |
| uv_i | input | 1 | Undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| drive_en_o | output | 1 | Output stage enable |
| intermit_o | output | 1 | Intermittent drive active |
| stall_latched_o | output | 1 | Rotor constraint latch |
| pwr_save_o | output | 1 | Power-saving (stop) state |

## Verification
Most internal errors show up at the ports within a single tick. A stall counter that clears on the wrong tachometer polarity, or that keeps counting under a fault, changes when the latch sets by at least one tick. This is visible when the 31st tick is checked. A clock-loss counter or burst phase that is off by one shifts intermit_o, or the on/off pattern of drive_en_o, on the very next tick. A state register that leaves the latch on a clock edge lets drive_en_o rise again a few cycles after that edge, which the bench checks on every step.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_STOP  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } sup_state_e;
endpackage

// File: rtl/mps_sync_edge.sv
module mps_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0,
  parameter bit   RISE    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o = chain_q[STAGES-1];

  generate
    if (RISE) begin : g_rise
      assign edge_o = chain_q[STAGES-1] & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~chain_q[STAGES-1] & prev_q;
    end
  endgenerate
endmodule

// File: rtl/mps_tick_timer.sv
module mps_tick_timer #(
  parameter int LIMIT = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic expired_o
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  // clear wins over tick; saturates at LIMIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/mps_burst_gen.sv
module mps_burst_gen #(
  parameter int ON_TICKS  = 1,
  parameter int OFF_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  output logic on_o
);
  localparam int PERIOD = ON_TICKS + OFF_TICKS;
  localparam int W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  localparam logic [W-1:0] ON_LIM = W'(ON_TICKS);

  logic [W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else if (!active_i) ph_q <= '0;
    else if (tick_i) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign on_o = (ph_q < ON_LIM);
endmodule

// File: rtl/motor_prot_sup.sv
module motor_prot_sup
  import mps_pkg::*;
#(
  parameter int INIT_TICKS     = 2,
  parameter int STALL_TICKS    = 31,
  parameter int CLK_LOSS_TICKS = 2,
  parameter int INT_ON_TICKS   = 1,
  parameter int INT_OFF_TICKS  = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_n_i,
  input  logic tach_i,
  input  logic ref_i,
  input  logic uv_i,
  input  logic ot_i,
  output logic drive_en_o,
  output logic intermit_o,
  output logic stall_latched_o,
  output logic pwr_save_o
);
  sup_state_e state_q, state_d;

  logic run_n_s, tach_edge, ref_edge, uv_s, ot_s, fault;
  logic unused_tach_lvl, unused_ref_lvl, unused_run_edge, unused_uv_edge, unused_ot_edge;
  logic init_done, stall_exp, loss_exp, burst_on;
  logic in_run;

  mps_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .RISE(1'b1)) i_sync_run (
    .clk_i, .rst_ni, .d_i(run_n_i), .lvl_o(run_n_s), .edge_o(unused_run_edge));
  mps_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISE(1'b1)) i_sync_tach (
    .clk_i, .rst_ni, .d_i(tach_i), .lvl_o(unused_tach_lvl), .edge_o(tach_edge));
  mps_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISE(1'b0)) i_sync_ref (
    .clk_i, .rst_ni, .d_i(ref_i), .lvl_o(unused_ref_lvl), .edge_o(ref_edge));
  mps_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISE(1'b1)) i_sync_uv (
    .clk_i, .rst_ni, .d_i(uv_i), .lvl_o(uv_s), .edge_o(unused_uv_edge));
  mps_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISE(1'b1)) i_sync_ot (
    .clk_i, .rst_ni, .d_i(ot_i), .lvl_o(ot_s), .edge_o(unused_ot_edge));

  assign fault  = uv_s | ot_s;
  assign in_run = (state_q == ST_RUN);

  mps_tick_timer #(.LIMIT(INIT_TICKS)) i_init_tmr (
    .clk_i, .rst_ni, .tick_i, .clear_i(state_q != ST_INIT), .expired_o(init_done));

  // stall count frozen at zero outside run and while a fault removes drive
  mps_tick_timer #(.LIMIT(STALL_TICKS)) i_stall_tmr (
    .clk_i, .rst_ni, .tick_i, .clear_i(!in_run || tach_edge || fault), .expired_o(stall_exp));

  mps_tick_timer #(.LIMIT(CLK_LOSS_TICKS)) i_loss_tmr (
    .clk_i, .rst_ni, .tick_i, .clear_i(!in_run || ref_edge), .expired_o(loss_exp));

  mps_burst_gen #(.ON_TICKS(INT_ON_TICKS), .OFF_TICKS(INT_OFF_TICKS)) i_burst (
    .clk_i, .rst_ni, .tick_i, .active_i(in_run && loss_exp), .on_o(burst_on));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:  if (init_done) state_d = run_n_s ? ST_STOP : ST_RUN;
      ST_STOP:  if (!run_n_s) state_d = ST_RUN;
      ST_RUN: begin
        if (run_n_s) state_d = ST_STOP;
        else if (stall_exp) state_d = ST_LATCH;
      end
      ST_LATCH: if (run_n_s) state_d = ST_STOP;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT;
    else state_q <= state_d;
  end

  assign drive_en_o      = in_run && !fault && (!loss_exp || burst_on);
  assign intermit_o      = in_run && loss_exp;
  assign stall_latched_o = (state_q == ST_LATCH);
  assign pwr_save_o      = (state_q == ST_STOP);
endmodule

// File: rtl/motor_prot_sup_chk.sv
module motor_prot_sup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_n_i,
  input logic uv_i,
  input logic ot_i,
  input logic drive_en_o,
  input logic intermit_o,
  input logic stall_latched_o,
  input logic pwr_save_o
);
  p_stop_no_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_save_o |-> !drive_en_o);

  p_latch_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_latched_o |-> !drive_en_o);

  p_latch_exit_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_latched_o |=> (stall_latched_o || pwr_save_o));

  p_fault_no_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((uv_i || ot_i) && $past(uv_i || ot_i) && $past(uv_i || ot_i, 2) && $past(uv_i || ot_i, 3))
    |-> !drive_en_o);

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pwr_save_o, stall_latched_o, intermit_o}));
endmodule

bind motor_prot_sup motor_prot_sup_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_n_i(run_n_i), .uv_i(uv_i), .ot_i(ot_i),
  .drive_en_o(drive_en_o), .intermit_o(intermit_o),
  .stall_latched_o(stall_latched_o), .pwr_save_o(pwr_save_o));

// File: tb/test_motor_prot_sup.sv
module test_motor_prot_sup;
  localparam int INIT_T = 2, STALL_T = 31, LOSS_T = 2, ON_T = 1, OFF_T = 3;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic rn = 1'b1, tach = 1'b0, refc = 1'b0, uv = 1'b0, ot = 1'b0;
  logic drive_en, intermit, latched, pwr_save;

  int vectors = 0, errors = 0, cycles = 0;

  // bench model state: 0 init, 1 stop, 2 run, 3 latched
  int m_st = 0, m_init = 0, m_stall = 0, m_loss = 0, m_ph = 0;
  logic m_tach = 1'b0, m_ref = 1'b0;

  always #2 clk = ~clk;

  motor_prot_sup #(
    .INIT_TICKS(INIT_T), .STALL_TICKS(STALL_T), .CLK_LOSS_TICKS(LOSS_T),
    .INT_ON_TICKS(ON_T), .INT_OFF_TICKS(OFF_T), .SYNC_STAGES(2)
  ) i_motor_prot_sup (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .run_n_i(rn), .tach_i(tach),
    .ref_i(refc), .uv_i(uv), .ot_i(ot), .drive_en_o(drive_en),
    .intermit_o(intermit), .stall_latched_o(latched), .pwr_save_o(pwr_save));

  function automatic logic exp_drive();
    return (m_st == 2) && !(uv || ot) && ((m_loss < LOSS_T) || (m_ph < ON_T));
  endfunction
  function automatic logic exp_int();
    return (m_st == 2) && (m_loss == LOSS_T);
  endfunction

  task automatic check(string tag);
    logic [3:0] act, exp;
    act = {drive_en, intermit, latched, pwr_save};
    exp = {exp_drive(), exp_int(), logic'(m_st == 3), logic'(m_st == 1)};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {drive,intermit,latched,pwr_save} actual %b expected %b", tag, act, exp);
    end
  endtask

  // apply current levels, optionally one tick, update model, check
  task automatic step(bit do_tick, string tag);
    logic fault, trise, rfall;
    repeat (6) @(negedge clk);
    fault = uv || ot;
    trise = !m_tach && tach;
    rfall = m_ref && !refc;
    m_tach = tach;
    m_ref  = refc;
    if (m_st == 1 && !rn) m_st = 2;
    else if ((m_st == 2 || m_st == 3) && rn) m_st = 1;
    if (m_st == 2) begin
      if (trise || fault) m_stall = 0;
      if (rfall) begin m_loss = 0; m_ph = 0; end
    end else begin
      m_stall = 0; m_loss = 0; m_ph = 0;
    end
    if (do_tick) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (5) @(negedge clk);
      if (m_st == 0) begin
        m_init++;
        if (m_init == INIT_T) m_st = rn ? 1 : 2;
      end else if (m_st == 2) begin
        if (m_loss == LOSS_T) m_ph = (m_ph == ON_T + OFF_T - 1) ? 0 : m_ph + 1;
        if (!fault && m_stall < STALL_T) m_stall++;
        if (m_loss < LOSS_T) m_loss++;
        if (m_stall == STALL_T) begin m_st = 3; m_stall = 0; m_loss = 0; m_ph = 0; end
      end
    end
    check(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1");
    rst_ni = 1'b1;
    step(0, "R1");
    step(1, "R1");
    step(1, "R2");
    rn = 1'b0;
    step(0, "R3");
    for (int i = 0; i < 6; i++) begin
      tach = ~tach; refc = ~refc;
      step(1, "R3");
    end
    // clock stops, tachometer still turning
    for (int i = 0; i < 10; i++) begin
      tach = ~tach;
      step(1, (i < 2) ? "R6" : "R7");
    end
    if (refc == 1'b0) begin refc = 1'b1; step(0, "R8"); end
    refc = 1'b0;
    step(0, "R8");
    // falling-only tachometer must not clear stall count
    tach = 1'b1; step(0, "R5");
    tach = 1'b0; step(1, "R5");
    for (int i = 0; i < STALL_T - 2; i++) begin
      refc = ~refc;
      step(1, "R5");
    end
    refc = ~refc;
    step(1, "R4");
    for (int i = 0; i < 6; i++) begin
      refc = ~refc;
      step(1, "R9");
    end
    rn = 1'b1; step(0, "R9");
    rn = 1'b0; step(0, "R3");
    uv = 1'b1;
    for (int i = 0; i < STALL_T + 5; i++) begin
      refc = ~refc;
      step(1, "R10");
    end
    uv = 1'b0; step(0, "R10");
    ot = 1'b1; step(1, "R10");
    ot = 1'b0; tach = ~tach; refc = ~refc; step(1, "R10");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 50) tach = ~tach;
      if ($urandom_range(99) < 45) refc = ~refc;
      if ($urandom_range(99) < 2)  rn = ~rn;
      if ($urandom_range(99) < 3)  uv = ~uv;
      if ($urandom_range(99) < 3)  ot = ~ot;
      step($urandom_range(99) < 60, "R11");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule